// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a two-part logical address into a physical address. A request gives a segment number, an offset within that segment and an access kind (read, write or execute). The segment number selects one entry of a small table. Each entry holds a base physical address, a segment length, a validity bit and three permission bits. A separate length register states how many segment numbers, counted from zero, are legal.

Before the base is added, each request passes four checks in a fixed order: the segment-number bound, the entry's validity, the offset against the segment length, and the access kind against the entry's permissions. The first check that fails sets a cause code and suppresses the address. A response leaves the block one clock after its request. Table entries and the length register are loaded through a simple write port. Each write counts from the next cycle onward.

Top module: `seg_xlate`

## Requirements
- R1: Reset clears every entry's validity bit and sets the length register to 0. While reset is asserted, rsp_valid is 0. Until a length is written, every request returns cause 1.
- R2: A request sampled at a rising edge with req_valid high gives rsp_valid high after that same edge. rsp_valid is low after any edge where req_valid was low.
- R3: A request whose segment number is greater than or equal to the length register returns cause 1. The length register may hold any value from 0 to 2^SEG_W, so a length of 16 makes segment 15 legal.
- R4: A request to a legal segment whose entry has its validity bit clear returns cause 2.
- R5: A request to a valid, legal segment whose offset is not strictly less than the entry's length field (OFF_W+1 bits wide) returns cause 3. A length of 0 rejects every offset, and a length of 2^OFF_W accepts every offset.
- R6: Permission bits are perm[0]=read, perm[1]=write, perm[2]=execute. Access kind 0 is read, 1 is write, 2 is execute. Kind 3 is reserved and is never permitted. A request that passes R3 to R5 but whose kind is not permitted returns cause 4.
- R7: When several checks would fail, the reported cause follows this order: bound (1), then validity (2), then length (3), then permission (4).
- R8: A request that passes all checks returns cause 0 and rsp_paddr = (base + offset) mod 2^BASE_W.
- R9: Whenever the response carries a nonzero cause, rsp_paddr is 0.
- R10: A table-entry write and a request in the same cycle: the request uses the entry's old contents. A request in the next cycle uses the new contents.
- R11: A length-register write and a request in the same cycle: the request uses the old length. A request in the next cycle uses the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Write one table entry |
| tbl_idx | input | SEG_W | Entry to write |
| tbl_base | input | BASE_W | Base physical address to store |
| tbl_limit | input | OFF_W+1 | Segment length to store |
| tbl_valid | input | 1 | Validity bit to store |
| tbl_perm | input | 3 | Permission bits to store (read, write, execute at bits 0, 1, 2) |
| len_we | input | 1 | Write the length register |
| len_val | input | SEG_W+1 | New number of legal segments |
| req_valid | input | 1 | Translation request present |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_cause | output | 3 | 0 success, 1 bound, 2 invalid, 3 length, 4 permission |
| rsp_paddr | output | BASE_W | Physical address, 0 on a fault |

## Verification
The bench builds the block with its default parameters: SEG_W=4, OFF_W=16 and BASE_W=24. With SEG_W=4 the table has 16 entries, so every entry can be loaded and a length of exactly 16 can make the last segment legal. With OFF_W=16 the length field is 17 bits, so both extremes of R5 can be exercised: a length of 0, and a length of 65536 tested against offset 0xFFFF. With a 24-bit base, random bases near the top of the address space produce sums that wrap, which tests the modulo rule of R8. Tables, lengths, offsets and access kinds are drawn at random with a fixed seed, with offsets biased toward the entry's length boundary. Directed cases cover the priority order and the same-cycle write ordering.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      FLT_NONE    = 3'd0,
      FLT_BOUND   = 3'd1,
      FLT_INVALID = 3'd2,
      FLT_LIMIT   = 3'd3,
      FLT_PERM    = 3'd4
   } flt_cause_e;

   localparam int PERM_W  = 3;
   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_EX = 2;

   function automatic logic kind_allowed(input logic [1:0] kind,
                                         input logic [PERM_W-1:0] perm);
      case (acc_kind_e'(kind))
         ACC_READ:  return perm[PERM_RD];
         ACC_WRITE: return perm[PERM_WR];
         ACC_EXEC:  return perm[PERM_EX];
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W  = 4,
   parameter int OFF_W  = 16,
   parameter int BASE_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEG_W-1:0]  wr_idx,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [OFF_W:0]    wr_limit,
   input  logic              wr_valid,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic              len_en,
   input  logic [SEG_W:0]    len_in,
   input  logic [SEG_W-1:0]  rd_idx,
   output logic [BASE_W-1:0] rd_base,
   output logic [OFF_W:0]    rd_limit,
   output logic              rd_valid,
   output logic [PERM_W-1:0] rd_perm,
   output logic [SEG_W:0]    len_q
);

   localparam int NSEG  = 1 << SEG_W;
   localparam int LIM_W = OFF_W + 1;

   logic [BASE_W-1:0] base_a  [NSEG];
   logic [LIM_W-1:0]  limit_a [NSEG];
   logic              valid_a [NSEG];
   logic [PERM_W-1:0] perm_a  [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_ent
      logic              hit;
      logic [BASE_W-1:0] base_r;
      logic [LIM_W-1:0]  limit_r;
      logic              valid_r;
      logic [PERM_W-1:0] perm_r;

      assign hit = wr_en && (wr_idx == SEG_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_r  <= '0;
            limit_r <= '0;
            valid_r <= 1'b0;
            perm_r  <= '0;
         end else if (hit) begin
            base_r  <= wr_base;
            limit_r <= wr_limit;
            valid_r <= wr_valid;
            perm_r  <= wr_perm;
         end
      end

      assign base_a[g]  = base_r;
      assign limit_a[g] = limit_r;
      assign valid_a[g] = valid_r;
      assign perm_a[g]  = perm_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q <= '0;
      else if (len_en) len_q <= len_in;
   end

   assign rd_base  = base_a[rd_idx];
   assign rd_limit = limit_a[rd_idx];
   assign rd_valid = valid_a[rd_idx];
   assign rd_perm  = perm_a[rd_idx];

endmodule

// File: rtl/seg_xlate_eval.sv
module seg_xlate_eval
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W  = 4,
   parameter int OFF_W  = 16,
   parameter int BASE_W = 24
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   input  logic [1:0]        kind,
   input  logic [SEG_W:0]    len,
   input  logic [BASE_W-1:0] ent_base,
   input  logic [OFF_W:0]    ent_limit,
   input  logic              ent_valid,
   input  logic [PERM_W-1:0] ent_perm,
   output logic [2:0]        cause,
   output logic [BASE_W-1:0] paddr
);

   logic [BASE_W-1:0] off_ext;
   flt_cause_e        cause_e;

   if (BASE_W == OFF_W) begin : g_same_w
      assign off_ext = off;
   end else begin : g_zext
      assign off_ext = {{(BASE_W-OFF_W){1'b0}}, off};
   end

   always_comb begin
      if ({1'b0, seg} >= len)               cause_e = FLT_BOUND;
      else if (!ent_valid)                  cause_e = FLT_INVALID;
      else if ({1'b0, off} >= ent_limit)    cause_e = FLT_LIMIT;
      else if (!kind_allowed(kind, ent_perm)) cause_e = FLT_PERM;
      else                                  cause_e = FLT_NONE;
   end

   assign cause = cause_e;
   assign paddr = (cause_e == FLT_NONE) ? (ent_base + off_ext) : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W  = 4,
   parameter int OFF_W  = 16,
   parameter int BASE_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_we,
   input  logic [SEG_W-1:0]  tbl_idx,
   input  logic [BASE_W-1:0] tbl_base,
   input  logic [OFF_W:0]    tbl_limit,
   input  logic              tbl_valid,
   input  logic [2:0]        tbl_perm,
   input  logic              len_we,
   input  logic [SEG_W:0]    len_val,
   input  logic              req_valid,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [1:0]        req_kind,
   output logic              rsp_valid,
   output logic [2:0]        rsp_cause,
   output logic [BASE_W-1:0] rsp_paddr
);

   if (SEG_W < 1 || SEG_W > 8) begin : g_bad_seg_w
      $error("seg_xlate: SEG_W must lie in 1..8");
   end
   if (OFF_W < 1 || BASE_W < OFF_W) begin : g_bad_off_w
      $error("seg_xlate: need 1 <= OFF_W <= BASE_W");
   end

   logic [BASE_W-1:0] ent_base;
   logic [OFF_W:0]    ent_limit;
   logic              ent_valid;
   logic [PERM_W-1:0] ent_perm;
   logic [SEG_W:0]    len_q;
   logic [2:0]        ev_cause;
   logic [BASE_W-1:0] ev_paddr;

   seg_xlate_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_idx   (tbl_idx),
      .wr_base  (tbl_base),
      .wr_limit (tbl_limit),
      .wr_valid (tbl_valid),
      .wr_perm  (tbl_perm),
      .len_en   (len_we),
      .len_in   (len_val),
      .rd_idx   (req_seg),
      .rd_base  (ent_base),
      .rd_limit (ent_limit),
      .rd_valid (ent_valid),
      .rd_perm  (ent_perm),
      .len_q    (len_q)
   );

   seg_xlate_eval #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_eval (
      .seg       (req_seg),
      .off       (req_off),
      .kind      (req_kind),
      .len       (len_q),
      .ent_base  (ent_base),
      .ent_limit (ent_limit),
      .ent_valid (ent_valid),
      .ent_perm  (ent_perm),
      .cause     (ev_cause),
      .paddr     (ev_paddr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_cause <= '0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_cause <= req_valid ? ev_cause : 3'd0;
         rsp_paddr <= req_valid ? ev_paddr : '0;
      end
   end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int SEG_W  = 4,
   parameter int OFF_W  = 16,
   parameter int BASE_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              len_we,
   input logic              req_valid,
   input logic [SEG_W-1:0]  req_seg,
   input logic [OFF_W-1:0]  req_off,
   input logic [SEG_W:0]    len_q,
   input logic [BASE_W-1:0] ent_base,
   input logic [OFF_W:0]    ent_limit,
   input logic              ent_valid,
   input logic              rsp_valid,
   input logic [2:0]        rsp_cause,
   input logic [BASE_W-1:0] rsp_paddr
);

   logic len_loaded;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_loaded <= 1'b0;
      else if (len_we) len_loaded <= 1'b1;
   end

   // R1
   unloaded_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !len_loaded) |-> (rsp_cause == 3'd1));

   // R2
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R2
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R3
   seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ({1'b0, req_seg} >= len_q)) |=> (rsp_cause == 3'd1));

   // R4
   invalid_ent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ({1'b0, req_seg} < len_q) && !ent_valid) |=> (rsp_cause == 3'd2));

   // R5
   off_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ({1'b0, req_seg} < len_q) && ent_valid &&
       ({1'b0, req_off} >= ent_limit)) |=> (rsp_cause == 3'd3));

   // R8
   paddr_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_cause == 3'd0) |->
      (rsp_paddr == $past(ent_base + BASE_W'(req_off))));

   // R9
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_cause != 3'd0) |-> (rsp_paddr == '0));

endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .len_we    (len_we),
   .req_valid (req_valid),
   .req_seg   (req_seg),
   .req_off   (req_off),
   .len_q     (len_q),
   .ent_base  (ent_base),
   .ent_limit (ent_limit),
   .ent_valid (ent_valid),
   .rsp_valid (rsp_valid),
   .rsp_cause (rsp_cause),
   .rsp_paddr (rsp_paddr)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;

   localparam int SEG_W  = 4;
   localparam int OFF_W  = 16;
   localparam int BASE_W = 24;
   localparam int NSEG   = 1 << SEG_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tbl_we = 1'b0;
   logic [SEG_W-1:0]  tbl_idx = '0;
   logic [BASE_W-1:0] tbl_base = '0;
   logic [OFF_W:0]    tbl_limit = '0;
   logic              tbl_valid = 1'b0;
   logic [2:0]        tbl_perm = '0;
   logic              len_we = 1'b0;
   logic [SEG_W:0]    len_val = '0;
   logic              req_valid = 1'b0;
   logic [SEG_W-1:0]  req_seg = '0;
   logic [OFF_W-1:0]  req_off = '0;
   logic [1:0]        req_kind = '0;
   logic              rsp_valid;
   logic [2:0]        rsp_cause;
   logic [BASE_W-1:0] rsp_paddr;

   always #5 clk = ~clk;

   seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .BASE_W(BASE_W)) dut (.*);

   // reference model of the table
   logic [BASE_W-1:0] m_base  [NSEG];
   logic [OFF_W:0]    m_limit [NSEG];
   logic              m_valid [NSEG];
   logic [2:0]        m_perm  [NSEG];
   logic [SEG_W:0]    m_len;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;
   logic [2:0]        e_cause;
   logic [BASE_W-1:0] e_paddr;

   function automatic logic [2:0] ref_cause(input logic [SEG_W-1:0] s,
                                            input logic [OFF_W-1:0] o,
                                            input logic [1:0] k);
      if ({1'b0, s} >= m_len)            return 3'd1;
      if (!m_valid[s])                   return 3'd2;
      if ({1'b0, o} >= m_limit[s])       return 3'd3;
      if (k == 2'd3 || !m_perm[s][k])    return 3'd4;
      return 3'd0;
   endfunction

   function automatic string tag_of(input logic [2:0] c);
      case (c)
         3'd0: return "R8";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic init_model();
      for (int i = 0; i < NSEG; i++) begin
         m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 1'b0; m_perm[i] = '0;
      end
      m_len = '0;
   endtask

   // drive an entry write; model updated by commit_ent after the edge
   task automatic drive_ent(input int i, input logic [BASE_W-1:0] b,
                            input logic [OFF_W:0] l, input logic v, input logic [2:0] p);
      tbl_we = 1'b1; tbl_idx = SEG_W'(i); tbl_base = b;
      tbl_limit = l; tbl_valid = v; tbl_perm = p;
   endtask

   task automatic commit_ent();
      m_base[tbl_idx] = tbl_base; m_limit[tbl_idx] = tbl_limit;
      m_valid[tbl_idx] = tbl_valid; m_perm[tbl_idx] = tbl_perm;
      tbl_we = 1'b0;
   endtask

   task automatic wr_ent(input int i, input logic [BASE_W-1:0] b,
                         input logic [OFF_W:0] l, input logic v, input logic [2:0] p);
      drive_ent(i, b, l, v, p);
      @(negedge clk);
      commit_ent();
   endtask

   task automatic wr_len(input logic [SEG_W:0] n);
      len_we = 1'b1; len_val = n;
      @(negedge clk);
      m_len = n; len_we = 1'b0;
   endtask

   task automatic issue(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o,
                        input logic [1:0] k);
      req_valid = 1'b1; req_seg = s; req_off = o; req_kind = k;
      e_cause = ref_cause(s, o, k);
      e_paddr = (e_cause == 3'd0) ? (m_base[s] + BASE_W'(o)) : '0;
   endtask

   task automatic collect(input string tag);
      string t;
      @(negedge clk);
      t = (tag == "") ? tag_of(e_cause) : tag;
      chk({t, " R2 rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk({t, " cause"}, 32'(rsp_cause), 32'(e_cause));
      chk({t, (e_cause == 3'd0) ? " R8 paddr" : " R9 paddr"}, 32'(rsp_paddr), 32'(e_paddr));
      req_valid = 1'b0;
   endtask

   task automatic do_req(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o,
                         input logic [1:0] k, input string tag);
      issue(s, o, k);
      collect(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 watchdog act=timeout exp=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5E6A_11C3));
      init_model();
      repeat (3) @(negedge clk);
      chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: nothing loaded
      do_req(4'd0, 16'd0, 2'd0, "R1");
      do_req(4'd15, 16'h1234, 2'd2, "R1");
      @(negedge clk);
      chk("R2 idle rsp_valid", 32'(rsp_valid), 32'd0);

      // R4: length set, entries still invalid
      wr_len(5'd16);
      do_req(4'd3, 16'd0, 2'd0, "R4");

      // R5 extremes, R8 wrap
      wr_ent(0, 24'h001000, 17'd0, 1'b1, 3'b111);
      do_req(4'd0, 16'd0, 2'd0, "R5");
      wr_ent(1, 24'h200000, 17'h10000, 1'b1, 3'b111);
      do_req(4'd1, 16'hFFFF, 2'd1, "R5");
      wr_ent(2, 24'hFFFFF0, 17'h100, 1'b1, 3'b001);
      do_req(4'd2, 16'h20, 2'd0, "R8");
      do_req(4'd2, 16'hFF, 2'd0, "R8");
      do_req(4'd2, 16'h100, 2'd0, "R5");

      // R6 permissions
      do_req(4'd2, 16'h10, 2'd1, "R6");
      do_req(4'd2, 16'h10, 2'd2, "R6");
      do_req(4'd1, 16'h10, 2'd3, "R6");
      wr_ent(3, 24'h000400, 17'h40, 1'b1, 3'b100);
      do_req(4'd3, 16'h3F, 2'd2, "R6");
      do_req(4'd3, 16'h3F, 2'd0, "R6");

      // R7 priority
      wr_ent(4, 24'h0, 17'd0, 1'b0, 3'b000);
      do_req(4'd4, 16'h5, 2'd3, "R7");
      wr_ent(4, 24'h0, 17'd0, 1'b1, 3'b000);
      do_req(4'd4, 16'h5, 2'd3, "R7");
      wr_ent(4, 24'h0, 17'h8, 1'b1, 3'b000);
      do_req(4'd4, 16'h5, 2'd3, "R7");
      wr_len(5'd4);
      do_req(4'd4, 16'h5, 2'd0, "R7");

      // R3 boundary
      do_req(4'd3, 16'h1, 2'd2, "R3");
      wr_len(5'd3);
      do_req(4'd3, 16'h1, 2'd2, "R3");
      wr_ent(15, 24'h00ABC0, 17'h10, 1'b1, 3'b111);
      wr_len(5'd16);
      do_req(4'd15, 16'h2, 2'd0, "R3");
      wr_len(5'd15);
      do_req(4'd15, 16'h2, 2'd0, "R3");
      wr_len(5'd16);

      // R10: entry write and request in the same cycle
      drive_ent(5, 24'h030000, 17'h100, 1'b1, 3'b011);
      issue(4'd5, 16'h10, 2'd0);
      collect("R10 old");
      commit_ent();
      do_req(4'd5, 16'h10, 2'd0, "R10 new");

      // R11: length write and request in the same cycle
      len_we = 1'b1; len_val = 5'd2;
      issue(4'd5, 16'h10, 2'd0);
      collect("R11 old");
      m_len = 5'd2; len_we = 1'b0;
      do_req(4'd5, 16'h10, 2'd0, "R11 new");

      // random rounds
      for (int rnd = 0; rnd < 8; rnd++) begin
         for (int i = 0; i < NSEG; i++) begin
            logic [OFF_W:0]    l;
            logic [BASE_W-1:0] b;
            case ($urandom_range(0, 4))
               0: l = '0;
               1: l = 17'h10000;
               2: l = 17'($urandom_range(1, 16));
               default: l = 17'($urandom_range(0, 17'h10000));
            endcase
            b = ($urandom_range(0, 3) == 0) ? (24'hFFFFFF - 24'($urandom_range(0, 255)))
                                            : 24'($urandom);
            wr_ent(i, b, l, ($urandom_range(0, 4) != 0), 3'($urandom));
         end
         wr_len(5'($urandom_range(0, 16)));
         for (int n = 0; n < 200; n++) begin
            logic [SEG_W-1:0] s;
            logic [OFF_W-1:0] o;
            s = 4'($urandom);
            case ($urandom_range(0, 3))
               0: o = 16'($urandom);
               1: o = 16'(m_limit[s] - 17'd1);
               2: o = 16'(m_limit[s]);
               default: o = 16'($urandom_range(0, 15));
            endcase
            issue(s, o, 2'($urandom));
            collect("");
         end
      end

      @(negedge clk);
      chk("R2 idle end", 32'(rsp_valid), 32'd0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule